// File: doc/BRIEF.md
# Two-Wire Serial Memory Target Engine

This block is the target side of a two-wire serial memory port. It samples the clock and data lines in the system clock domain and recognises the bus Start and Stop conditions. It moves bytes most significant bit first and drives acknowledge bits through an output-enable that pulls the data line low. It owns a 17-bit word pointer. It serves reads through a synchronous read port: it asserts `rd_en` with `rd_addr`, and the memory answers on `rd_data` on the following clock. Received write bytes leave on a strobe together with their target address, and a separate commit block consumes them. That block reports an internal programming cycle on `wc_busy`, and while it does so the engine refuses to acknowledge a selection, so a host can poll.

A selection byte follows every Start. It holds the fixed prefix 1010 in bits 7..4, the strapped select code in bits 3..2, word-address bit 16 in bit 1, and the direction in bit 0 (1 = read). A write transfer then supplies word-address bits 15..8 and bits 7..0, and any further bytes are data. A random read is a write transfer that carries only the address, followed by a repeated Start and a read selection. A read without a preceding address begins at the current pointer. The memory depth is a parameter, so the read wrap point can be reduced while the address field layout stays the same.

Top module: `serial_mem_target`

## Requirements
- R1: After reset `sda_oe`, `wr_strobe`, `wr_end` and `rd_en` are all 0, and the word pointer is 0.
- R2: A selection byte is acknowledged (data line held low during the ninth clock) only when bits 7..4 equal 1010 and bits 3..2 equal `strap_sel`. On any other value the engine does not acknowledge and ignores every byte until the next Start.
- R3: In a write transfer the two bytes after the selection are acknowledged and, together with selection bit 1 as bit 16, form the word address {bit1, first byte, second byte}. Each later data byte is acknowledged and appears for one cycle on `wr_strobe` with `wr_addr` and `wr_data`.
- R4: Successive write data bytes advance only the low log2(PAGE_BYTES) address bits, wrapping within the page (…FF is followed by …00 of the same page).
- R5: A Stop or a repeated Start that ends a write transfer carrying at least one data byte produces exactly one single-cycle `wr_end` pulse. An address-only write produces none.
- R6: A random read returns the memory byte at the address just loaded, fetched through a one-cycle `rd_en` with that address on `rd_addr`.
- R7: While the host acknowledges each read byte, the engine supplies the byte at the next address.
- R8: The pointer holds the last accessed address plus one (page-wrapped after writes) and persists across transfers. A read with no address phase starts there.
- R9: During reads the pointer wraps from MEM_DEPTH-1 to 0.
- R10: While `wc_busy` is 1, a selection byte is not acknowledged, whatever its direction bit. Once `wc_busy` is 0, the same selection is acknowledged.
- R11: A host not-acknowledge ends the read. The engine releases the data line, fetches no further byte, and after a Stop the data line is released.
- R12: `sda_oe` changes only after a synchronized falling clock edge, or on a Start or Stop. It is stable while the clock is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| strap_sel | input | 2 | Strapped select code compared with selection bits 3..2 |
| wc_busy | input | 1 | Commit block is programming; refuse selection |
| rd_en | output | 1 | One-cycle read request |
| rd_addr | output | 17 | Read word address |
| rd_data | input | 8 | Read data, valid the cycle after rd_en |
| wr_strobe | output | 1 | One-cycle write byte strobe |
| wr_addr | output | 17 | Target address of the strobed byte |
| wr_data | output | 8 | Strobed write byte |
| wr_end | output | 1 | One-cycle end-of-write pulse |

## Verification
The assertions take for granted that each clock-line phase lasts several system clocks and that the host moves the data line at least three system clocks after the clock line falls. Otherwise the synchronizer delay would make an ordinary data change look like a Start or Stop, and the output-enable timing property would not apply. The bench holds each clock phase for ten system clocks and moves the data line five clocks into the low phase. It builds repeated Starts by releasing the data line while the clock is low, and all word addresses it sends lie below the default depth.

// File: rtl/smt_pkg.sv
// Package: shared types and constants for the serial memory target engine.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package smt_pkg;

    // Protocol phase of the engine.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,   // ignoring the bus until a Start
        ST_SEL  = 3'd1,   // receiving the selection byte
        ST_AHI  = 3'd2,   // receiving word-address bits 15..8
        ST_ALO  = 3'd3,   // receiving word-address bits 7..0
        ST_WDAT = 3'd4,   // receiving write data bytes
        ST_RDAT = 3'd5    // sending read data bytes
    } smt_state_e;

    // Fixed prefix carried in bits 7..4 of the selection byte.
    localparam logic [3:0] SEL_PREFIX = 4'b1010;

    // Bit counter positions: 0..7 data bits, then the acknowledge phases.
    localparam logic [3:0] CNT_LAST_BIT = 4'd7;
    localparam logic [3:0] CNT_BYTE_IN  = 4'd8;
    localparam logic [3:0] CNT_ACK_SLOT = 4'd9;

endpackage

// File: rtl/smt_line_sampler.sv
// Module: smt_line_sampler
// Brings the two bus lines into the system clock domain through a
// SYNC_STAGES-deep flop chain and derives clock edges and bus conditions.
// Assumes each line phase lasts longer than the chain delay; no glitch
// filtering is done. Both chains reset to the idle-high bus level.
module smt_line_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_cond,
    output logic stop_cond
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [LAST:0] scl_pipe;
    logic [LAST:0] sda_pipe;
    logic          scl_q;
    logic          sda_q;
    logic          scl_s;

    // Synchronizer chains plus one history flop per line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[LAST-1:0], scl_i};
            sda_pipe <= {sda_pipe[LAST-1:0], sda_i};
            scl_q    <= scl_pipe[LAST];
            sda_q    <= sda_pipe[LAST];
        end
    end

    // Edge and condition decode from the current and previous samples.
    always_comb begin
        scl_s      = scl_pipe[LAST];
        sda_s      = sda_pipe[LAST];
        scl_rise   = scl_s & ~scl_q;
        scl_fall   = ~scl_s & scl_q;
        start_cond = scl_s & scl_q & sda_q & ~sda_s;
        stop_cond  = scl_s & scl_q & ~sda_q & sda_s;
    end

endmodule

// File: rtl/smt_word_ptr.sv
// Module: smt_word_ptr
// Holds the word pointer. A load takes a full address; a read step
// advances through the whole memory and wraps at MEM_DEPTH-1; a write step
// advances only the in-page bits. Assumes MEM_DEPTH <= 2**ADDR_W and
// PAGE_BYTES a power of two no larger than the memory.
module smt_word_ptr #(
    parameter int ADDR_W     = 17,
    parameter int MEM_DEPTH  = 131072,
    parameter int PAGE_BYTES = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              step_rd,
    input  logic              step_wr,
    output logic [ADDR_W-1:0] ptr
);
    localparam int                PAGE_W    = $clog2(PAGE_BYTES);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(MEM_DEPTH - 1);

    logic [ADDR_W-1:0] next_rd;
    logic [ADDR_W-1:0] next_wr;

    // Read successor: linear with wrap at the top of the memory.
    always_comb begin
        next_rd = (ptr == LAST_ADDR) ? '0 : ptr + ADDR_W'(1);
    end

    // Write successor: page bits held, in-page bits roll over.
    generate
        if (PAGE_W >= ADDR_W) begin : g_flat_page
            always_comb next_wr = ptr + ADDR_W'(1);
        end else begin : g_split_page
            always_comb next_wr = {ptr[ADDR_W-1:PAGE_W],
                                   ptr[PAGE_W-1:0] + PAGE_W'(1)};
        end
    endgenerate

    // Pointer register; load has priority over the steps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (load) begin
            ptr <= load_val;
        end else if (step_rd) begin
            ptr <= next_rd;
        end else if (step_wr) begin
            ptr <= next_wr;
        end
    end

endmodule

// File: rtl/serial_mem_target.sv
// Module: serial_mem_target
// Target-side protocol engine for a two-wire serial memory. Decodes the
// selection byte, collects the word address, forwards write bytes to a
// commit block and serves reads from a synchronous read port (data one
// clock after rd_en). Assumes bus phases of several system clocks and
// rd_data held stable between fetches.
module serial_mem_target #(
    parameter int ADDR_W      = 17,
    parameter int MEM_DEPTH   = 131072,
    parameter int PAGE_BYTES  = 256,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [1:0]        strap_sel,
    input  logic              wc_busy,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        rd_data,
    output logic              wr_strobe,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              wr_end
);
    import smt_pkg::*;

    localparam int HI_W = ADDR_W - 9;

    smt_state_e        state;
    smt_state_e        next_state;
    logic [3:0]        bit_cnt;
    logic [7:0]        rx_sh;
    logic [7:0]        tx_sh;
    logic [7:0]        rx_nxt;
    logic [HI_W-1:0]   addr_hi;
    logic              page_bit;
    logic              ack_pend;
    logic              wrote_any;
    logic [ADDR_W-1:0] ptr;

    logic sda_s, scl_rise_w, scl_fall_w, start_w, stop_w;
    logic bus_event, byte_rx, sel_hit, fetch_sel, fetch_seq;
    logic ptr_load, step_rd, step_wr;
    logic [ADDR_W-1:0] load_addr;

    smt_line_sampler #(
        .SYNC_STAGES (SYNC_STAGES)
    ) sampler_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .sda_s      (sda_s),
        .scl_rise   (scl_rise_w),
        .scl_fall   (scl_fall_w),
        .start_cond (start_w),
        .stop_cond  (stop_w)
    );

    smt_word_ptr #(
        .ADDR_W     (ADDR_W),
        .MEM_DEPTH  (MEM_DEPTH),
        .PAGE_BYTES (PAGE_BYTES)
    ) ptr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ptr_load),
        .load_val (load_addr),
        .step_rd  (step_rd),
        .step_wr  (step_wr),
        .ptr      (ptr)
    );

    // Byte-completion and pointer events shared by the FSM and the pointer.
    always_comb begin
        bus_event = start_w | stop_w;
        rx_nxt    = {rx_sh[6:0], sda_s};
        byte_rx   = !bus_event && (state != ST_IDLE) && (state != ST_RDAT)
                    && scl_rise_w && (bit_cnt == CNT_LAST_BIT);
        sel_hit   = (rx_nxt[7:4] == SEL_PREFIX) && (rx_nxt[3:2] == strap_sel)
                    && !wc_busy;
        fetch_sel = byte_rx && (state == ST_SEL) && sel_hit && rx_nxt[0];
        fetch_seq = !bus_event && (state == ST_RDAT) && scl_rise_w
                    && (bit_cnt == CNT_ACK_SLOT) && !sda_s;
        ptr_load  = byte_rx && (state == ST_ALO);
        step_rd   = fetch_sel | fetch_seq;
        step_wr   = byte_rx && (state == ST_WDAT);
        load_addr = {page_bit, addr_hi, rx_nxt};
    end

    // Protocol sequencer: bit counting, acknowledge drive and byte routing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            next_state <= ST_IDLE;
            bit_cnt    <= '0;
            rx_sh      <= '0;
            tx_sh      <= '0;
            addr_hi    <= '0;
            page_bit   <= 1'b0;
            ack_pend   <= 1'b0;
            wrote_any  <= 1'b0;
            sda_oe     <= 1'b0;
            rd_en      <= 1'b0;
            rd_addr    <= '0;
            wr_strobe  <= 1'b0;
            wr_addr    <= '0;
            wr_data    <= '0;
            wr_end     <= 1'b0;
        end else begin
            rd_en     <= 1'b0;
            wr_strobe <= 1'b0;
            wr_end    <= 1'b0;
            if (bus_event) begin
                state     <= start_w ? ST_SEL : ST_IDLE;
                bit_cnt   <= '0;
                sda_oe    <= 1'b0;
                ack_pend  <= 1'b0;
                wr_end    <= wrote_any;
                wrote_any <= 1'b0;
            end else if (state != ST_IDLE) begin
                if (scl_rise_w && (bit_cnt < CNT_BYTE_IN)) begin
                    bit_cnt <= bit_cnt + 4'd1;
                    rx_sh   <= rx_nxt;
                end else if (scl_rise_w && (bit_cnt == CNT_ACK_SLOT)
                             && (state == ST_RDAT)) begin
                    if (!sda_s) begin
                        next_state <= ST_RDAT;
                    end else begin
                        state <= ST_IDLE;
                    end
                end else if (scl_fall_w) begin
                    if (bit_cnt == CNT_BYTE_IN) begin
                        sda_oe  <= ack_pend;
                        bit_cnt <= CNT_ACK_SLOT;
                    end else if (bit_cnt == CNT_ACK_SLOT) begin
                        state    <= next_state;
                        bit_cnt  <= '0;
                        ack_pend <= 1'b0;
                        if (next_state == ST_RDAT) begin
                            tx_sh  <= rd_data;
                            sda_oe <= ~rd_data[7];
                        end else begin
                            sda_oe <= 1'b0;
                        end
                    end else if ((state == ST_RDAT) && (bit_cnt != 4'd0)) begin
                        tx_sh  <= {tx_sh[6:0], 1'b0};
                        sda_oe <= ~tx_sh[6];
                    end
                end

                if (byte_rx) begin
                    unique case (state)
                        ST_SEL: begin
                            if (sel_hit) begin
                                ack_pend   <= 1'b1;
                                page_bit   <= rx_nxt[1];
                                next_state <= rx_nxt[0] ? ST_RDAT : ST_AHI;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                        ST_AHI: begin
                            ack_pend   <= 1'b1;
                            addr_hi    <= rx_nxt[HI_W-1:0];
                            next_state <= ST_ALO;
                        end
                        ST_ALO: begin
                            ack_pend   <= 1'b1;
                            next_state <= ST_WDAT;
                        end
                        ST_WDAT: begin
                            ack_pend   <= 1'b1;
                            wr_strobe  <= 1'b1;
                            wr_addr    <= ptr;
                            wr_data    <= rx_nxt;
                            wrote_any  <= 1'b1;
                            next_state <= ST_WDAT;
                        end
                        default: ;
                    endcase
                end

                if (step_rd) begin
                    rd_en   <= 1'b1;
                    rd_addr <= ptr;
                end
            end
        end
    end

endmodule

// File: rtl/smt_checker.sv
// Module: smt_checker
// Protocol properties for serial_mem_target, bound to every instance.
// Assumes the bus timing stated in the brief (phases of several clocks).
module smt_checker (
    input logic clk,
    input logic rst_n,
    input logic sda_oe,
    input logic rd_en,
    input logic wr_strobe,
    input logic wr_end,
    input logic scl_fall,
    input logic start_c,
    input logic stop_c
);

    // R12
    oe_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> $past(scl_fall || start_c || stop_c));

    // R3
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_strobe, rd_en, wr_end}));

    // R5
    end_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_end |=> !wr_end);

    // R11
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_c |=> !sda_oe);

    // R6
    fetch_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> !rd_en);

endmodule

bind serial_mem_target smt_checker chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_oe    (sda_oe),
    .rd_en     (rd_en),
    .wr_strobe (wr_strobe),
    .wr_end    (wr_end),
    .scl_fall  (scl_fall_w),
    .start_c   (start_w),
    .stop_c    (stop_w)
);

// File: tb/serial_mem_target_tb_top.sv
`timescale 1ns/1ps
// Bench: directed host scenarios against serial_mem_target with a
// computed read-data model and a log of write strobes.
module serial_mem_target_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        wc_busy = 1'b0;
    logic [1:0]  strap_sel = 2'b10;
    logic        sda_oe;
    logic        rd_en;
    logic [16:0] rd_addr;
    logic [7:0]  rd_data = 8'h00;
    logic        wr_strobe;
    logic [16:0] wr_addr;
    logic [7:0]  wr_data;
    logic        wr_end;
    wire         sda_line = sda_m & ~sda_oe;

    int n_chk = 0;
    int n_bad = 0;
    int wn = 0;
    int endn = 0;
    logic [16:0] wa [0:31];
    logic [7:0]  wd [0:31];

    always #2.5 clk = ~clk;

    serial_mem_target dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_m),
        .sda_i     (sda_line),
        .sda_oe    (sda_oe),
        .strap_sel (strap_sel),
        .wc_busy   (wc_busy),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .wr_strobe (wr_strobe),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .wr_end    (wr_end)
    );

    function automatic logic [7:0] pat(input logic [16:0] a);
        return a[7:0] ^ a[15:8] ^ {a[16], 7'h35};
    endfunction

    // Memory model and write log.
    always @(posedge clk) begin
        if (rd_en) rd_data <= pat(rd_addr);
        if (wr_strobe && wn < 32) begin
            wa[wn] <= wr_addr;
            wd[wn] <= wr_data;
            wn <= wn + 1;
        end
        if (wr_end) endn <= endn + 1;
    end

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wclk(5);
        scl_m = 1'b1; wclk(10);
        sda_m = 1'b0; wclk(10);
        scl_m = 1'b0; wclk(5);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wclk(5);
        scl_m = 1'b1; wclk(10);
        sda_m = 1'b1; wclk(10);
    endtask

    // Sends a byte and returns the target's acknowledge; checks R12 on the way.
    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic s1, s2;
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wclk(5);
            scl_m = 1'b1; wclk(10);
            scl_m = 1'b0; wclk(5);
        end
        sda_m = 1'b1; wclk(5);
        scl_m = 1'b1; wclk(3);
        s1 = sda_line; wclk(6);
        s2 = sda_line; wclk(1);
        chk("R12 ack level stable while clock high", s2, s1);
        acked = ~s1;
        scl_m = 1'b0; wclk(5);
    endtask

    task automatic recv_byte(input logic host_ack, output logic [7:0] d);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wclk(5);
            scl_m = 1'b1; wclk(5);
            d[i] = sda_line; wclk(5);
            scl_m = 1'b0; wclk(5);
        end
        sda_m = host_ack ? 1'b0 : 1'b1; wclk(5);
        scl_m = 1'b1; wclk(10);
        scl_m = 1'b0; wclk(5);
        sda_m = 1'b1;
    endtask

    // Start plus address-only write of a 17-bit word address.
    task automatic load_addr(input logic [16:0] a, input string tag);
        logic ak;
        bus_start();
        send_byte({6'b101010, a[16], 1'b0}, ak); chk({tag, " sel ack"}, ak, 1);
        send_byte(a[15:8], ak);                  chk({tag, " hi ack"}, ak, 1);
        send_byte(a[7:0], ak);                   chk({tag, " lo ack"}, ak, 1);
    endtask

    task automatic t_reset();
        chk("R1 sda_oe after reset", sda_oe, 0);
        chk("R1 wr_strobe after reset", wr_strobe, 0);
        chk("R1 wr_end after reset", wr_end, 0);
        chk("R1 rd_en after reset", rd_en, 0);
    endtask

    task automatic t_select();
        logic ak;
        int base = wn;
        bus_start();
        send_byte(8'hA4, ak); chk("R2 wrong strap nack", ak, 0);
        send_byte(8'h00, ak); chk("R2 ignored after mismatch", ak, 0);
        bus_stop();
        bus_start();
        send_byte(8'hB8, ak); chk("R2 wrong prefix nack", ak, 0);
        bus_stop();
        chk("R2 no strobe after mismatch", wn, base);
        bus_start();
        send_byte(8'hA8, ak); chk("R2 match ack", ak, 1);
        bus_stop();
    endtask

    task automatic t_byte_write();
        logic ak;
        logic [7:0] d;
        int base = wn;
        int eb = endn;
        load_addr(17'h12345, "R3");
        send_byte(8'h5C, ak); chk("R3 data ack", ak, 1);
        bus_stop(); wclk(4);
        chk("R3 strobe count", wn, base + 1);
        chk("R3 strobe address", wa[base], 17'h12345);
        chk("R3 strobe data", wd[base], 8'h5C);
        chk("R5 end pulse on stop", endn, eb + 1);
        bus_start();
        send_byte(8'hA9, ak); chk("R8 current read sel ack", ak, 1);
        recv_byte(1'b0, d);
        bus_stop();
        chk("R8 current read after write", d, pat(17'h12346));
    endtask

    task automatic t_page();
        logic ak;
        int base = wn;
        load_addr(17'h040FE, "R4");
        send_byte(8'h11, ak);
        send_byte(8'h22, ak);
        send_byte(8'h33, ak);
        bus_stop(); wclk(4);
        chk("R4 page strobes", wn, base + 3);
        chk("R4 first address", wa[base], 17'h040FE);
        chk("R4 last in page", wa[base + 1], 17'h040FF);
        chk("R4 wrap to page start", wa[base + 2], 17'h04000);
        chk("R4 wrapped data", wd[base + 2], 8'h33);
    endtask

    task automatic t_end_rs();
        logic ak;
        int eb = endn;
        load_addr(17'h00010, "R5");
        send_byte(8'h77, ak);
        bus_start(); wclk(4);
        chk("R5 end pulse on repeated start", endn, eb + 1);
        send_byte(8'hA8, ak);
        bus_stop(); wclk(4);
        chk("R5 no end pulse for address-only write", endn, eb + 1);
    endtask

    task automatic t_rand_read();
        logic ak;
        logic [7:0] d;
        load_addr(17'h10A10, "R6");
        bus_start();
        send_byte(8'hA9, ak); chk("R6 read sel ack", ak, 1);
        recv_byte(1'b0, d);
        bus_stop();
        chk("R6 random read data", d, pat(17'h10A10));
    endtask

    task automatic t_seq_read();
        logic ak;
        logic [7:0] d;
        load_addr(17'h00101, "R7");
        bus_start();
        send_byte(8'hA9, ak);
        for (int k = 0; k < 4; k++) begin
            recv_byte(k != 3, d);
            chk("R7 sequential data", d, pat(17'h00101 + 17'(k)));
        end
        chk("R11 line released after host nack", sda_line, 1);
        bus_stop();
        chk("R11 line released after stop", sda_oe, 0);
        bus_start();
        send_byte(8'hA9, ak);
        recv_byte(1'b0, d);
        bus_stop();
        chk("R11 no extra fetch after nack", d, pat(17'h00105));
    endtask

    task automatic t_wrap();
        logic ak;
        logic [7:0] d;
        load_addr(17'h1FFFF, "R9");
        bus_start();
        send_byte(8'hA9, ak);
        recv_byte(1'b1, d); chk("R9 top byte", d, pat(17'h1FFFF));
        recv_byte(1'b0, d); chk("R9 wrap to zero", d, pat(17'h00000));
        bus_stop();
    endtask

    task automatic t_busy();
        logic ak;
        logic [7:0] d;
        wc_busy = 1'b1;
        bus_start();
        send_byte(8'hA8, ak); chk("R10 busy write sel nack", ak, 0);
        bus_stop();
        bus_start();
        send_byte(8'hA9, ak); chk("R10 busy read sel nack", ak, 0);
        bus_stop();
        wc_busy = 1'b0;
        bus_start();
        send_byte(8'hA9, ak); chk("R10 ack after busy clears", ak, 1);
        recv_byte(1'b0, d);
        bus_stop();
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        wclk(5);
        rst_n = 1'b1;
        wclk(3);
        t_reset();
        t_select();
        t_byte_write();
        t_page();
        t_end_rs();
        t_rand_read();
        t_seq_read();
        t_wrap();
        t_busy();
        wclk(10);
        finish_run();
    end

endmodule